// File: doc/BRIEF.md
# Key-Combination Reset Detector

This block watches a small group of push-button inputs and asks for a system reset when the operator holds down a chosen combination of keys. The keys are active low. A 2-bit selection input decides which keys form the combination. Zero switches the function off. Larger codes add keys to the set. The reset request is raised only while every key in the set reads low at the same time. Keys outside the set have no effect.

Each raw pin first passes through a two-flop synchroniser. The synchronised levels are also brought out on their own port, so software can still read the keys as ordinary inputs. Three states decide when the request is raised:

- `KR_IDLE`: the combination is not held.
- `KR_COUNT`: the combination is held and the minimum-duration filter is counting.
- `KR_FIRE`: the request is raised.

The named transitions are:

- idle-to-fire, when the filter is bypassed.
- idle-to-count, when the filter is active.
- count-to-fire, when the programmed duration is reached or the filter is switched off while counting.
- count-to-idle, when the combination breaks. The count then restarts from scratch.
- fire-to-idle, when the combination breaks.

The request is a level that follows the combination. Feeding it into the reset tree is done outside this block.

Top module: `keyrst_detect`

## Requirements
- R1: `combo_sel_i` encodes the key set as follows: 0 disables detection, so the request stays low; 1 selects keys 0 and 1; 2 selects keys 0 to 2; 3 selects keys 0 to 3.
- R2: The request is raised only when every selected key is low at once. The levels of unselected keys have no effect.
- R3: With `filt_en_i` low, `rst_req_o` rises on the third rising clock edge after the selected keys go low. That is two synchroniser stages plus the state register.
- R4: With `filt_en_i` high and `filt_len_i` = L ≥ 1, `rst_req_o` rises on edge 3+L after the keys go low. L = 0 behaves like a disabled filter.
- R5: Any break in the combination while counting reloads the filter. A later hold must then last the full L cycles again.
- R6: The request stays high while the combination holds. It falls on the third edge after a selected key returns high. It falls on the first edge after `combo_sel_i` becomes 0.
- R7: `key_level_o` shows each pin's level two rising edges after the pin changes. Its reset value is all ones.
- R8: While `rst_n` is low, `rst_req_o` is low and the controller is idle.
- R9: Clearing `filt_en_i` while counting raises the request on the next edge, provided the combination still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_pin_i | input | NUM_KEYS | Raw key pin levels, low = pressed |
| combo_sel_i | input | 2 | Key-set selection code |
| filt_en_i | input | 1 | Minimum-duration filter enable |
| filt_len_i | input | CNT_W | Required hold time in clock cycles |
| key_level_o | output | NUM_KEYS | Synchronised key levels for general-purpose reading |
| rst_req_o | output | 1 | Reset request level |

## Verification
The bench builds the block with NUM_KEYS = 4 and CNT_W = 8. With four keys, every non-zero selection code covers a different key set, and the widest code uses all the pins. The 8-bit length field allows hold times of 3, 5, 6 and 20 cycles. At those lengths the bench can check the exact cycle of every rise. It also covers a broken hold that must restart the count, and a filter switched off partway through a count.

// File: rtl/keyrst_pkg.sv
package keyrst_pkg;

    localparam int KR_SEL_W = 2;

    typedef enum logic [1:0] {
        KR_IDLE  = 2'd0,
        KR_COUNT = 2'd1,
        KR_FIRE  = 2'd2
    } kr_state_e;

endpackage

// File: rtl/keyrst_sync.sv
module keyrst_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    // Per-bit two-stage synchroniser; idle (released) keys read high.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic sync_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= d_i[i];
                sync_q <= meta_q;
            end
        end

        assign q_o[i] = sync_q;
    end

endmodule

// File: rtl/keyrst_combo.sv
module keyrst_combo
    import keyrst_pkg::*;
#(
    parameter int NUM_KEYS = 4
) (
    input  logic [NUM_KEYS-1:0] lvl_i,
    input  logic [KR_SEL_W-1:0] sel_i,
    output logic                hit_o
);

    logic [NUM_KEYS-1:0] mask;
    logic [NUM_KEYS-1:0] low_ok;

    // Selection code k (k > 0) takes keys 0..k into the combination.
    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_key
        assign mask[i]   = (sel_i != '0) && (i <= int'(sel_i));
        assign low_ok[i] = ~mask[i] | ~lvl_i[i];
    end

    assign hit_o = (sel_i != '0) && (&low_ok);

endmodule

// File: rtl/keyrst_fsm.sv
module keyrst_fsm
    import keyrst_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             filt_en_i,
    input  logic [CNT_W-1:0] filt_len_i,
    output logic             req_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    kr_state_e        state_q;
    kr_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             bypass;
    logic             done;

    assign bypass = !filt_en_i || (filt_len_i == '0);
    assign done   = (cnt_q >= filt_len_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KR_IDLE: begin
                if (hit_i) begin
                    state_d = bypass ? KR_FIRE : KR_COUNT;
                end
            end
            KR_COUNT: begin
                if (!hit_i) begin
                    state_d = KR_IDLE;
                end else if (bypass || done) begin
                    state_d = KR_FIRE;
                end
            end
            KR_FIRE: begin
                if (!hit_i) begin
                    state_d = KR_IDLE;
                end
            end
            default: state_d = KR_IDLE;
        endcase
    end

    // Hold-time counter: loads one on entry to KR_COUNT, saturates, clears elsewhere.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d == KR_COUNT) begin
            if (state_q != KR_COUNT) begin
                cnt_q <= CNT_ONE;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_ONE;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    // Output process
    always_comb begin
        req_o = (state_q == KR_FIRE);
    end

endmodule

// File: rtl/keyrst_detect.sv
module keyrst_detect
    import keyrst_pkg::*;
#(
    parameter int NUM_KEYS = 4,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_pin_i,
    input  logic [1:0]          combo_sel_i,
    input  logic                filt_en_i,
    input  logic [CNT_W-1:0]    filt_len_i,
    output logic [NUM_KEYS-1:0] key_level_o,
    output logic                rst_req_o
);

    logic [NUM_KEYS-1:0] lvl_sync;
    logic                combo_hit;

    keyrst_sync #(
        .WIDTH (NUM_KEYS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (key_pin_i),
        .q_o   (lvl_sync)
    );

    keyrst_combo #(
        .NUM_KEYS (NUM_KEYS)
    ) u_combo (
        .lvl_i (lvl_sync),
        .sel_i (combo_sel_i),
        .hit_o (combo_hit)
    );

    keyrst_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (combo_hit),
        .filt_en_i  (filt_en_i),
        .filt_len_i (filt_len_i),
        .req_o      (rst_req_o)
    );

    assign key_level_o = lvl_sync;

endmodule

// File: rtl/keyrst_detect_chk.sv
module keyrst_detect_chk #(
    parameter int NUM_KEYS = 4,
    parameter int CNT_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_KEYS-1:0] key_pin_i,
    input logic [1:0]          combo_sel_i,
    input logic                filt_en_i,
    input logic [CNT_W-1:0]    filt_len_i,
    input logic [NUM_KEYS-1:0] key_level_o,
    input logic                rst_req_o
);

    logic       cond_chk;
    logic [1:0] since_rst;

    // Combination as seen on the synchronised output port.
    always_comb begin
        cond_chk = (combo_sel_i != 2'd0);
        for (int i = 0; i < NUM_KEYS; i++) begin
            if ((i <= int'(combo_sel_i)) && key_level_o[i]) begin
                cond_chk = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_SEL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (combo_sel_i == 2'd0) |=> !rst_req_o); // R1

    AST_REQ_NEEDS_COMBO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(cond_chk)); // R2

    AST_UNFILTERED_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_chk && !filt_en_i) |=> rst_req_o); // R3

    AST_FILTER_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 2'd3) && $rose(rst_req_o) && $past(filt_en_i) && ($past(filt_len_i) != '0))
        |-> ($past(cond_chk) && $past(cond_chk, 2))); // R4

    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o && !cond_chk) |=> !rst_req_o); // R6

    AST_LEVEL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (key_level_o == $past(key_pin_i, 2))); // R7

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!rst_req_o); // R8
        end
    end

endmodule

bind keyrst_detect keyrst_detect_chk #(
    .NUM_KEYS (NUM_KEYS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_pin_i   (key_pin_i),
    .combo_sel_i (combo_sel_i),
    .filt_en_i   (filt_en_i),
    .filt_len_i  (filt_len_i),
    .key_level_o (key_level_o),
    .rst_req_o   (rst_req_o)
);

// File: tb/keyrst_detect_tb.sv
module keyrst_detect_tb;

    localparam int NK = 4;
    localparam int CW = 8;
    localparam int NV = 9;

    localparam int         V_SEL [NV] = '{1, 1, 2, 3, 3, 0, 2, 2, 3};
    localparam int         V_FEN [NV] = '{0, 0, 0, 0, 1, 0, 1, 1, 0};
    localparam int         V_LEN [NV] = '{0, 0, 0, 0, 3, 0, 0, 6, 0};
    localparam logic [3:0] V_PIN [NV] = '{4'b0000, 4'b1100, 4'b1010, 4'b1000, 4'b0000,
                                          4'b0000, 4'b1000, 4'b1000, 4'b0001};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NK-1:0] key_pin_i = '1;
    logic [1:0]    combo_sel_i = 2'd0;
    logic          filt_en_i = 1'b0;
    logic [CW-1:0] filt_len_i = '0;
    logic [NK-1:0] key_level_o;
    logic          rst_req_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    keyrst_detect #(.NUM_KEYS(NK), .CNT_W(CW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_pin_i   (key_pin_i),
        .combo_sel_i (combo_sel_i),
        .filt_en_i   (filt_en_i),
        .filt_len_i  (filt_len_i),
        .key_level_o (key_level_o),
        .rst_req_o   (rst_req_o)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [NK-1:0] act, input logic [NK-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic model_cond(input int sel, input logic [3:0] p);
        if (sel == 0) return 1'b0;
        for (int i = 0; i <= sel; i++) begin
            if (p[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic idle_keys();
        key_pin_i = '1;
        step(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic exp_c;
        int   lat;
        string rn;

        @(negedge clk);
        step(2);
        // R8 / R7: reset state
        chk("R8", {3'b0, rst_req_o}, '0);
        chk("R7", key_level_o, 4'b1111);
        rst_n = 1'b1;
        step(2);

        // R7: synchroniser delay on the general-purpose read path (selection 0)
        key_pin_i = 4'b0110;
        step(1);
        chk("R7", key_level_o, 4'b1111);
        step(1);
        chk("R7", key_level_o, 4'b0110);
        idle_keys();

        // Vector table
        for (int v = 0; v < NV; v++) begin
            combo_sel_i = V_SEL[v][1:0];
            filt_en_i   = V_FEN[v][0];
            filt_len_i  = V_LEN[v][CW-1:0];
            idle_keys();
            exp_c = model_cond(V_SEL[v], V_PIN[v]);
            lat   = 3 + (((V_FEN[v] != 0) && (V_LEN[v] != 0)) ? V_LEN[v] : 0);
            if (V_SEL[v] == 0)                   rn = "R1";
            else if (!exp_c)                     rn = "R2";
            else if (V_FEN[v] != 0)              rn = "R4";
            else                                 rn = "R3";
            key_pin_i = V_PIN[v];
            for (int k = 1; k <= lat + 3; k++) begin
                step(1);
                chk(rn, {3'b0, rst_req_o}, {3'b0, (exp_c && (k >= lat))});
            end
            key_pin_i = '1;
            step(2);
            chk("R6", {3'b0, rst_req_o}, {3'b0, exp_c});
            step(1);
            chk("R6", {3'b0, rst_req_o}, '0);
        end

        // R5: broken hold reloads the filter
        combo_sel_i = 2'd3;
        filt_en_i   = 1'b1;
        filt_len_i  = 8'd5;
        idle_keys();
        key_pin_i = 4'b0000;
        step(4);
        key_pin_i = 4'b0001;
        step(2);
        key_pin_i = 4'b0000;
        for (int k = 1; k <= 9; k++) begin
            step(1);
            chk("R5", {3'b0, rst_req_o}, {3'b0, (k >= 8)});
        end
        idle_keys();

        // R9: filter cleared while counting
        filt_len_i = 8'd20;
        key_pin_i  = 4'b0000;
        step(6);
        chk("R9", {3'b0, rst_req_o}, '0);
        filt_en_i = 1'b0;
        step(1);
        chk("R9", {3'b0, rst_req_o}, 4'b0001);
        idle_keys();

        // R6: selection dropped to zero while firing
        key_pin_i = 4'b0000;
        step(4);
        chk("R6", {3'b0, rst_req_o}, 4'b0001);
        combo_sel_i = 2'd0;
        step(1);
        chk("R6", {3'b0, rst_req_o}, '0);

        // R8: reset while firing
        combo_sel_i = 2'd3;
        step(2);
        chk("R8", {3'b0, rst_req_o}, 4'b0001);
        rst_n = 1'b0;
        #1;
        chk("R8", {3'b0, rst_req_o}, '0);
        step(1);
        rst_n = 1'b1;
        step(1);
        chk("R8", {3'b0, rst_req_o}, '0);

        finish_run();
    end

endmodule